// File: doc/BRIEF.md
# Processor Module System Control Register File

This block is the system control register bank of a processor module. A host reaches it over a simple 32-bit register bus: a byte offset whose word index is the offset shifted right by two, a write strobe with write data, and read data that follows the offset in the same cycle. The bank holds an identity word, two oscillator settings that accept writes only while a 16-bit unlock key is held, a control word that drives an LED, a memory remap select and a reset request, two set/clear flag words, a free-running reference counter, a small local interrupt group, and a read-only window onto a memory-module descriptor.

Outputs go to the rest of the module. `reset_req` is a one-cycle request to the system reset logic. `remap` low means the boot flash appears at address zero, and high means it is withdrawn there. `led` drives an indicator. `int_flag` shows that the pending software interrupt is enabled on either the IRQ or the FIQ path. The reference counter advances at `REF_HZ` on average. A fractional clock-enable divider derives that rate from the `CLK_HZ` bus clock.

Top module: `cm_sysctl_regs`

## Requirements
- R1: A read of word index 0 returns 0x411A3001, index 4 returns 0x00100000, and index 1 returns 0. Index 6, indexes 32 to 35 and every other unmapped index inside the 0x000 to 0x1FF window return 0. Every offset at 0x200 or above also returns 0.
- R2: A write to index 5 (lock) stores only wdata[15:0]. While the stored value is 0xA05F, index 5 reads 0x0001A05F. Otherwise it reads the stored value, zero-extended.
- R3: Writes to index 2 (oscillator) and index 7 (auxiliary oscillator) update the register only while the lock holds 0xA05F. At any other time they leave the register unchanged.
- R4: A write to index 3 (control) with bit 3 set raises `reset_req` for exactly the one cycle after the write edge. Bit 0 is stored and drives `led`. Bit 2 is stored and drives `remap`. Reads of index 3 show only bits 0 and 2, so bit 3 always reads 0.
- R5: A write to index 12 ORs wdata into the flags word, and a write to index 13 clears the bits written as 1. A read of index 12 returns the flags. Indexes 14 and 15 act the same way on a second flags word. Reads of 13 and 15 return 0.
- R6: Index 10 reads 0 in the first cycle after reset. Its value then grows by exactly floor(n*REF_HZ/CLK_HZ) over any n cycles that begin on a divider phase of zero, and by one count at most per cycle. With the defaults, that is 192 counts per 1000 cycles.
- R7: IRQ enable: a write to index 18 ORs into it, a write to index 19 clears the bits written as 1, and a read of index 18 returns it. The FIQ enable behaves the same at indexes 26 and 27.
- R8: A write to index 20 with bit 0 set raises the software level, and a write to index 21 with bit 0 set clears it. The raw level reads at indexes 17, 25 and 20 (bit 0). Level AND the IRQ enable reads at index 16, and level AND the FIQ enable reads at index 24.
- R9: `int_flag` is high exactly when the software level is set and bit 0 of the IRQ enable or of the FIQ enable is set.
- R10: Reset values are: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init register (index 9) 0x00000112, and memory register (index 8) 0x00011122 ORed with the size code (0x10 for MEM_MB at least 256, 0x0C at least 128, 0x08 at least 64, 0x04 at least 32, else 0). Indexes 8 and 9 accept any write.
- R11: Offsets 0x100 to 0x17F read descriptor byte (offset>>2)&31 in bits 7:0. Byte 0 is 0x80, byte 1 is 0x08, and byte 31 is the density code (64, 32, 16, 4 or 2 for MEM_MB at least 256, 128, 64, 32, else). All other bytes are 0. Offsets 0x180 to 0x1FF read 0.
- R12: Writes to read-only or unmapped offsets (index 0, 16, the descriptor window) change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| reset_req | output | 1 | One-cycle system reset request |
| remap | output | 1 | Memory map select, high withdraws boot flash from zero |
| led | output | 1 | Indicator drive |
| int_flag | output | 1 | Enabled software interrupt pending |

## Verification
Assertions check on every cycle that:
- locked oscillator writes leave the register untouched;
- a reset request follows only a bus write;
- the reference counter never moves by more than one;
- a flag clear write leaves none of the written bits set;
- an enable set write leaves every written bit set.

Only the bench scenarios can show the exact read values: the constants, the 0x1A05F unlock image, the reset values, the descriptor bytes, and the exact count of 192 per 1000 cycles. The same holds for the width of the reset pulse and for the way `int_flag` follows the combinations of level and enables.

// File: rtl/cmr_pkg.sv
// Package: word indexes, constants and reset-value functions shared by the
// control register file. Assumes a 7-bit word index covering 0x000..0x1FF.
package cmr_pkg;
    typedef logic [6:0] widx_t;

    localparam widx_t IX_ID       = 7'd0;
    localparam widx_t IX_PROC     = 7'd1;
    localparam widx_t IX_OSC      = 7'd2;
    localparam widx_t IX_CTRL     = 7'd3;
    localparam widx_t IX_STAT     = 7'd4;
    localparam widx_t IX_LOCK     = 7'd5;
    localparam widx_t IX_AUXOSC   = 7'd7;
    localparam widx_t IX_SDRAM    = 7'd8;
    localparam widx_t IX_INIT     = 7'd9;
    localparam widx_t IX_REFCNT   = 7'd10;
    localparam widx_t IX_FLG_SET  = 7'd12;
    localparam widx_t IX_FLG_CLR  = 7'd13;
    localparam widx_t IX_NVF_SET  = 7'd14;
    localparam widx_t IX_NVF_CLR  = 7'd15;
    localparam widx_t IX_IRQ_STAT = 7'd16;
    localparam widx_t IX_IRQ_RAW  = 7'd17;
    localparam widx_t IX_IRQ_ENS  = 7'd18;
    localparam widx_t IX_IRQ_ENC  = 7'd19;
    localparam widx_t IX_SOFT_SET = 7'd20;
    localparam widx_t IX_SOFT_CLR = 7'd21;
    localparam widx_t IX_FIQ_STAT = 7'd24;
    localparam widx_t IX_FIQ_RAW  = 7'd25;
    localparam widx_t IX_FIQ_ENS  = 7'd26;
    localparam widx_t IX_FIQ_ENC  = 7'd27;

    localparam logic [31:0] ID_WORD    = 32'h411A_3001;
    localparam logic [31:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
    localparam logic [31:0] OSC_RST    = 32'h0100_0048;
    localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
    localparam logic [31:0] INIT_RST   = 32'h0000_0112;
    localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;

    // Memory register size code for a module of mb megabytes.
    function automatic logic [31:0] size_code(int mb);
        if (mb >= 256)     return 32'h10;
        else if (mb >= 128) return 32'h0C;
        else if (mb >= 64)  return 32'h08;
        else if (mb >= 32)  return 32'h04;
        else                return 32'h00;
    endfunction

    // Descriptor density byte for a module of mb megabytes.
    function automatic logic [7:0] density(int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    // One byte of the memory descriptor table.
    function automatic logic [7:0] desc_byte(logic [4:0] i, int mb);
        case (i)
            5'd0:    return 8'h80;
            5'd1:    return 8'h08;
            5'd31:   return density(mb);
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cmr_setclr_reg.sv
// Set/clear register: a set strobe ORs data in, a clear strobe removes the
// bits written as 1. Assumes the two strobes never share a cycle.
module cmr_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply set or clear writes to the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (set_en) q <= q | wdata;
        else if (clr_en) q <= q & ~wdata;
    end

    // R5: after a clear write none of the written bits remain
    a_r5_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/cmr_refcnt.sv
// Reference counter: a fractional accumulator turns the CLK_HZ clock into an
// average REF_HZ enable, which advances a free-running counter. Assumes
// REF_HZ <= CLK_HZ.
module cmr_refcnt #(
    parameter int CLK_HZ = 125_000_000,
    parameter int REF_HZ = 24_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam int ACC_W = $clog2(CLK_HZ + REF_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(REF_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;
    logic             tick;

    // Next accumulator phase and tick decision.
    always_comb begin
        sum  = acc + STEP;
        tick = (sum >= WRAP);
    end

    // Advance the divider phase and the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            count <= '0;
        end else begin
            acc   <= tick ? (sum - WRAP) : sum;
            if (tick) count <= count + 1'b1;
        end
    end

    // R6: the counter moves by at most one per cycle
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));
endmodule

// File: rtl/cmr_irq_group.sv
// Local interrupt group: one software level bit plus IRQ and FIQ enable words
// with set/clear write ports. Assumes one bus write per cycle.
module cmr_irq_group
    import cmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  widx_t        widx,
    input  logic [W-1:0] wdata,
    output logic         soft_lvl,
    output logic [W-1:0] irq_en,
    output logic [W-1:0] fiq_en
);
    logic irq_set, irq_clr, fiq_set, fiq_clr;

    // Decode the writes that target this group.
    always_comb begin
        irq_set = wr_en && (widx == IX_IRQ_ENS);
        irq_clr = wr_en && (widx == IX_IRQ_ENC);
        fiq_set = wr_en && (widx == IX_FIQ_ENS);
        fiq_clr = wr_en && (widx == IX_FIQ_ENC);
    end

    cmr_setclr_reg #(.W(W)) u_irq_en (
        .clk(clk), .rst_n(rst_n), .set_en(irq_set), .clr_en(irq_clr),
        .wdata(wdata), .q(irq_en));

    cmr_setclr_reg #(.W(W)) u_fiq_en (
        .clk(clk), .rst_n(rst_n), .set_en(fiq_set), .clr_en(fiq_clr),
        .wdata(wdata), .q(fiq_en));

    // Software interrupt level set and clear through bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_lvl <= 1'b0;
        else if (wr_en && widx == IX_SOFT_SET && wdata[0]) soft_lvl <= 1'b1;
        else if (wr_en && widx == IX_SOFT_CLR && wdata[0]) soft_lvl <= 1'b0;
    end

    // R7: an IRQ enable set write leaves every written bit set
    a_r7_irq_enset: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> ((irq_en & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/cm_sysctl_regs.sv
// Processor module system control register file. Decodes a word-indexed
// register bus, holds the lock-guarded oscillators, control, memory and init
// words, and returns read data combinationally. Assumes ADDR_W >= 10.
module cm_sysctl_regs
    import cmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CLK_HZ = 125_000_000,
    parameter int REF_HZ = 24_000_000,
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              reset_req,
    output logic              remap,
    output logic              led,
    output logic              int_flag
);
    localparam logic [31:0] SDRAM_RST = SDRAM_BASE | size_code(MEM_MB);

    logic        in_win;
    widx_t       widx;
    logic        bus_wr;
    logic        unlocked;
    logic [15:0] lock_q;
    logic [31:0] osc_q, auxosc_q, sdram_q, init_q;
    logic [31:0] flags_q, nvflags_q, refcnt;
    logic        soft_lvl;
    logic [31:0] irq_en, fiq_en;

    // Split the byte offset into window and word index.
    always_comb begin
        in_win   = (addr[ADDR_W-1:9] == '0);
        widx     = addr[8:2];
        bus_wr   = wr_en && in_win;
        unlocked = (lock_q == UNLOCK_KEY);
    end

    // Plain and lock-guarded storage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= '0;
            osc_q    <= OSC_RST;
            auxosc_q <= AUXOSC_RST;
            sdram_q  <= SDRAM_RST;
            init_q   <= INIT_RST;
        end else if (bus_wr) begin
            case (widx)
                IX_LOCK:   lock_q  <= wdata[15:0];
                IX_OSC:    if (unlocked) osc_q    <= wdata;
                IX_AUXOSC: if (unlocked) auxosc_q <= wdata;
                IX_SDRAM:  sdram_q <= wdata;
                IX_INIT:   init_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Control bits and the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led       <= 1'b0;
            remap     <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= bus_wr && (widx == IX_CTRL) && wdata[3];
            if (bus_wr && widx == IX_CTRL) begin
                led   <= wdata[0];
                remap <= wdata[2];
            end
        end
    end

    cmr_setclr_reg #(.W(32)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_en(bus_wr && widx == IX_FLG_SET),
        .clr_en(bus_wr && widx == IX_FLG_CLR),
        .wdata(wdata), .q(flags_q));

    cmr_setclr_reg #(.W(32)) u_nvflags (
        .clk(clk), .rst_n(rst_n),
        .set_en(bus_wr && widx == IX_NVF_SET),
        .clr_en(bus_wr && widx == IX_NVF_CLR),
        .wdata(wdata), .q(nvflags_q));

    cmr_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CNT_W(32)) u_refcnt (
        .clk(clk), .rst_n(rst_n), .count(refcnt));

    cmr_irq_group #(.W(32)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .widx(widx),
        .wdata(wdata), .soft_lvl(soft_lvl), .irq_en(irq_en), .fiq_en(fiq_en));

    // Combined enabled software interrupt.
    always_comb int_flag = soft_lvl && (irq_en[0] || fiq_en[0]);

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        if (in_win) begin
            if (widx[6:5] == 2'b10) begin
                rdata = {24'h0, desc_byte(widx[4:0], MEM_MB)};
            end else if (widx[6:5] == 2'b00) begin
                case (widx)
                    IX_ID:       rdata = ID_WORD;
                    IX_STAT:     rdata = STAT_WORD;
                    IX_OSC:      rdata = osc_q;
                    IX_CTRL:     rdata = {29'h0, remap, 1'b0, led};
                    IX_LOCK:     rdata = unlocked ? {15'h0, 1'b1, lock_q}
                                                  : {16'h0, lock_q};
                    IX_AUXOSC:   rdata = auxosc_q;
                    IX_SDRAM:    rdata = sdram_q;
                    IX_INIT:     rdata = init_q;
                    IX_REFCNT:   rdata = refcnt;
                    IX_FLG_SET:  rdata = flags_q;
                    IX_NVF_SET:  rdata = nvflags_q;
                    IX_IRQ_STAT: rdata = {31'h0, soft_lvl & irq_en[0]};
                    IX_IRQ_RAW:  rdata = {31'h0, soft_lvl};
                    IX_IRQ_ENS:  rdata = irq_en;
                    IX_SOFT_SET: rdata = {31'h0, soft_lvl};
                    IX_FIQ_STAT: rdata = {31'h0, soft_lvl & fiq_en[0]};
                    IX_FIQ_RAW:  rdata = {31'h0, soft_lvl};
                    IX_FIQ_ENS:  rdata = fiq_en;
                    default:     rdata = '0;
                endcase
            end
        end
    end

    // R3: locked oscillator writes leave the register unchanged
    a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win && widx == IX_OSC && lock_q != UNLOCK_KEY)
        |=> $stable(osc_q));

    // R4: a reset request only follows a bus write
    a_r4_req_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_en));
endmodule

// File: tb/cm_sysctl_regs_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module cm_sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        reset_req, remap, led, int_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [11:0] a;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    cm_sysctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .reset_req(reset_req), .remap(remap), .led(led),
        .int_flag(int_flag));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Driver: present a read offset and push the expected word.
    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = a;
        it.exp = exp; it.a = a; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compare the queued expectation shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                chk($sformatf("%s @0x%03h", it.tag, it.a), rdata, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] c1, c2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6: counter reads 0 one edge after reset release
        @(negedge clk); addr = 12'h028; #1 chk("R6 reset count", rdata, 32'h0);
        chk("R4 reset outputs", {28'h0, reset_req, remap, led, int_flag}, 32'h0);

        // R1 constants and zero reads
        rd(12'h000, 32'h411A_3001, "R1 id");
        rd(12'h004, 32'h0, "R1 proc");
        rd(12'h010, 32'h0010_0000, "R1 stat");
        rd(12'h018, 32'h0, "R1 bus count");
        rd(12'h084, 32'h0, "R1 voltage");
        rd(12'h0F0, 32'h0, "R1 unmapped");
        rd(12'h200, 32'h0, "R1 out of window");

        // R10 reset values and free writes
        rd(12'h008, 32'h0100_0048, "R10 osc reset");
        rd(12'h01C, 32'h0007_FEFF, "R10 auxosc reset");
        rd(12'h024, 32'h0000_0112, "R10 init reset");
        rd(12'h020, 32'h0001_112E, "R10 sdram reset");
        wr(12'h020, 32'hCAFE_0001);
        wr(12'h024, 32'h0000_0777);
        rd(12'h020, 32'hCAFE_0001, "R10 sdram write");
        rd(12'h024, 32'h0000_0777, "R10 init write");

        // R2/R3 lock key
        wr(12'h008, 32'h1234_5678);
        rd(12'h008, 32'h0100_0048, "R3 osc locked");
        wr(12'h014, 32'h1234_A05F);
        rd(12'h014, 32'h0001_A05F, "R2 unlocked read");
        wr(12'h008, 32'hDEAD_BEEF);
        wr(12'h01C, 32'h0000_1111);
        rd(12'h008, 32'hDEAD_BEEF, "R3 osc unlocked");
        rd(12'h01C, 32'h0000_1111, "R3 auxosc unlocked");
        wr(12'h014, 32'hFFFF_0042);
        rd(12'h014, 32'h0000_0042, "R2 low half stored");
        wr(12'h01C, 32'h0000_2222);
        rd(12'h01C, 32'h0000_1111, "R3 auxosc relocked");

        // R4 control
        @(negedge clk); wr_en = 1'b1; addr = 12'h00C; wdata = 32'h0000_000D;
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R4 reset pulse high", {31'h0, reset_req}, 32'h1);
        chk("R4 led/remap", {30'h0, remap, led}, 32'h3);
        @(negedge clk); #1;
        chk("R4 reset pulse single", {31'h0, reset_req}, 32'h0);
        rd(12'h00C, 32'h0000_0005, "R4 ctrl read bit3 zero");
        wr(12'h00C, 32'hFFFF_FFF2);
        rd(12'h00C, 32'h0, "R4 ctrl cleared");
        @(negedge clk); #1;
        chk("R4 remap low flash at zero", {30'h0, remap, led}, 32'h0);

        // R5 flags
        wr(12'h030, 32'h0000_F0F0);
        wr(12'h030, 32'h0000_000F);
        rd(12'h030, 32'h0000_F0FF, "R5 flags set");
        wr(12'h034, 32'h0000_00F0);
        rd(12'h030, 32'h0000_F00F, "R5 flags clear");
        rd(12'h034, 32'h0, "R5 clear reads 0");
        wr(12'h038, 32'h8000_0001);
        wr(12'h03C, 32'h0000_0001);
        rd(12'h038, 32'h8000_0000, "R5 nvflags");
        rd(12'h030, 32'h0000_F00F, "R5 flags independent");

        // R7/R8/R9 interrupt group
        wr(12'h048, 32'h0000_0005);
        wr(12'h04C, 32'h0000_0004);
        rd(12'h048, 32'h0000_0001, "R7 irq enable");
        wr(12'h068, 32'h0000_0006);
        rd(12'h068, 32'h0000_0006, "R7 fiq enable");
        wr(12'h050, 32'h0000_0003);
        rd(12'h044, 32'h1, "R8 irq raw");
        rd(12'h040, 32'h1, "R8 irq status");
        rd(12'h050, 32'h1, "R8 soft read");
        rd(12'h060, 32'h0, "R8 fiq status masked");
        #1 chk("R9 int_flag via irq", {31'h0, int_flag}, 32'h1);
        wr(12'h04C, 32'h0000_0001);
        #1 chk("R9 int_flag no enable", {31'h0, int_flag}, 32'h0);
        wr(12'h068, 32'h0000_0001);
        rd(12'h060, 32'h1, "R8 fiq status");
        #1 chk("R9 int_flag via fiq", {31'h0, int_flag}, 32'h1);
        wr(12'h054, 32'h0000_0001);
        rd(12'h064, 32'h0, "R8 soft clear");
        #1 chk("R9 int_flag cleared", {31'h0, int_flag}, 32'h0);
        wr(12'h06C, 32'hFFFF_FFFF);
        rd(12'h068, 32'h0, "R7 fiq clear");

        // R11 descriptor window
        rd(12'h100, 32'h80, "R11 desc 0");
        rd(12'h104, 32'h08, "R11 desc 1");
        rd(12'h17C, 32'h20, "R11 desc density");
        rd(12'h140, 32'h00, "R11 desc zero");
        rd(12'h180, 32'h0, "R11 upper window");

        // R12 ignored writes
        wr(12'h000, 32'h0);
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h100, 32'h0);
        rd(12'h000, 32'h411A_3001, "R12 id kept");
        rd(12'h048, 32'h0, "R12 enable kept");
        rd(12'h100, 32'h80, "R12 desc kept");

        // R6 rate: exactly 192 counts per 1000 cycles
        @(negedge clk); addr = 12'h028; #1 c1 = rdata;
        repeat (1000) @(negedge clk);
        #1 c2 = rdata;
        chk("R6 count per 1000 cycles", c2 - c1, 32'd192);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule